// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the 12-bit address of the next microinstruction on every clock. A 3-bit select from the current microinstruction picks the source of that address. The sources are:

- the sequential successor;
- an unconditional jump to a field of the microinstruction;
- a jump taken only when an external condition bit is high;
- a subroutine call, which records one return address;
- a return to that recorded address;
- a dispatch on the opcode of a fetched instruction.

Two instruction pipeline registers are filled from a 16-bit bus. On dispatch, the opcode held in one of them drives the address for one cycle, so the first microinstruction of the routine is fetched from there. At the same time, an internal 512-entry vector table supplies the continuation. The continuation is a fixed upper nibble joined to the 8-bit vector, and it becomes the sequential successor.

An 8-bit iteration counter can be loaded from the bus or from a microcode immediate. It is counted down by a step strobe. It raises a done flag while its value is zero, which lets microcode repeat a short sequence.

The microcode store itself lives outside the block. It is modelled only by the testbench.

Top module: `useq_next`

## Requirements
- R1: After reset, `addr` is 0, `loop_done` is 1, the sequential successor is 1, the return register holds 0 and both instruction registers hold 0.
- R2: Select codes 0, 6 and 7 load `addr` with the sequential successor. Outside dispatch, the successor is the previous address plus one, wrapping from 4095 to 0.
- R3: Select 1 loads `addr` with `jfield`, and the successor becomes `jfield`+1.
- R4: Select 2 loads `addr` with `jfield` when `cond` is 1. Otherwise it takes the sequential successor.
- R5: Select 3 stores the current sequential successor in the return register and loads `addr` with `jfield`.
- R6: Select 4 loads `addr` with the return register's value and leaves the register unchanged.
- R7: With `ir_shift` high, register A takes `ibus` and register B takes the old value of A. Otherwise both hold.
- R8: Select 5 takes the opcode (bits 15:7) of register A when `ir_pick` is 0, or of register B when it is 1. It sets `addr` to that 9-bit opcode zero-extended. The successor is {4'h4, v}, where v is the opcode's low 8 bits, inverted when opcode bit 8 is 1.
- R9: `lc_load_bus` loads the counter with `ibus[7:0]` and takes priority over `lc_load_imm`, which loads `lc_imm`. Otherwise `lc_step` decrements the counter, holding at zero. `loop_done` is 1 exactly while the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 3 | Next-address source select |
| jfield | input | 12 | Jump target field of the microinstruction |
| cond | input | 1 | Branch condition from the datapath |
| ibus | input | 16 | Instruction / data bus |
| ir_shift | input | 1 | Shift bus into instruction registers |
| ir_pick | input | 1 | Dispatch from A (0) or B (1) |
| lc_load_bus | input | 1 | Load counter from ibus[7:0] |
| lc_load_imm | input | 1 | Load counter from lc_imm |
| lc_imm | input | 8 | Counter immediate |
| lc_step | input | 1 | Decrement counter |
| addr | output | 12 | Current microcode address |
| loop_done | output | 1 | Counter is zero |

## Verification
The hardest state to reach is the successor left behind by a dispatch. It is visible only when the next cycle is sequential, a call, or a conditional branch that is not taken. The stimulus therefore follows each dispatch with one of these. It first shifts two distinct words through the instruction registers, so that A and B hold different opcodes. One opcode has bit 8 set, so the inverted vector path is exercised. Address wrap is reached by jumping to 4094 and stepping twice.

// File: rtl/useq_next.sv
module useq_next #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int OPW = 9,
  parameter int VW = 8,
  parameter int LCW = 8,
  parameter logic [AW-VW-1:0] UPPER = 4'h4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     sel,
  input  logic [AW-1:0]  jfield,
  input  logic           cond,
  input  logic [DW-1:0]  ibus,
  input  logic           ir_shift,
  input  logic           ir_pick,
  input  logic           lc_load_bus,
  input  logic           lc_load_imm,
  input  logic [LCW-1:0] lc_imm,
  input  logic           lc_step,
  output logic [AW-1:0]  addr,
  output logic           loop_done
);
  localparam int TBL = 1 << OPW;
  localparam logic [2:0] S_JMP = 3'd1, S_CND = 3'd2, S_CALL = 3'd3,
                         S_RET = 3'd4, S_DSP = 3'd5;

  logic [AW-1:0]  addr_q, nxt_q, sav_q, tgt, link;
  logic [DW-1:0]  ira_q, irb_q;
  logic [LCW-1:0] cnt_q;
  logic [VW-1:0]  vtab [TBL];

  for (genvar g = 0; g < TBL; g++) begin : g_vt
    localparam logic [OPW-1:0] IDX = OPW'(g);
    assign vtab[g] = IDX[OPW-1] ? ~IDX[VW-1:0] : IDX[VW-1:0];
  end

  wire [OPW-1:0] opc = ir_pick ? irb_q[DW-1 -: OPW] : ira_q[DW-1 -: OPW];
  wire [VW-1:0]  vec = vtab[opc];

  always_comb begin
    case (sel)
      S_JMP, S_CALL: tgt = jfield;
      S_CND:         tgt = cond ? jfield : nxt_q;
      S_RET:         tgt = sav_q;
      S_DSP:         tgt = AW'(opc);
      default:       tgt = nxt_q;
    endcase
    link = (sel == S_DSP) ? {UPPER, vec} : tgt + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      nxt_q  <= AW'(1);
      sav_q  <= '0;
      ira_q  <= '0;
      irb_q  <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= tgt;
      nxt_q  <= link;
      if (sel == S_CALL) sav_q <= nxt_q;
      if (ir_shift) begin
        ira_q <= ibus;
        irb_q <= ira_q;
      end
      if (lc_load_bus)                  cnt_q <= ibus[LCW-1:0];
      else if (lc_load_imm)             cnt_q <= lc_imm;
      else if (lc_step && cnt_q != '0)  cnt_q <= cnt_q - LCW'(1);
    end
  end

  assign addr      = addr_q;
  assign loop_done = (cnt_q == '0);
endmodule

module useq_next_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    sel,
  input logic [AW-1:0] jfield,
  input logic          cond,
  input logic          lc_load_bus,
  input logic          lc_load_imm,
  input logic [AW-1:0] addr,
  input logic          loop_done,
  input logic [AW-1:0] nxt_q,
  input logic [AW-1:0] sav_q
);
  AST_SEQ_TAKES_SUCC: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 || sel == 3'd6 || sel == 3'd7) |=> addr == $past(nxt_q)); // R2
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'd1 |=> addr == $past(jfield)); // R3
  AST_COND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd2 && cond) |=> addr == $past(jfield)); // R4
  AST_COND_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd2 && !cond) |=> addr == $past(nxt_q)); // R4
  AST_CALL_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'd3 |=> sav_q == $past(nxt_q)); // R5
  AST_RETURN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'd4 |=> (addr == $past(sav_q) && $stable(sav_q))); // R6
  AST_DISPATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'd5 |=> addr[AW-1:9] == '0); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_done && !lc_load_bus && !lc_load_imm) |=> loop_done); // R9
endmodule

bind useq_next useq_next_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .jfield(jfield), .cond(cond),
  .lc_load_bus(lc_load_bus), .lc_load_imm(lc_load_imm), .addr(addr),
  .loop_done(loop_done), .nxt_q(nxt_q), .sav_q(sav_q)
);

// File: tb/test_useq_next.sv
module test_useq_next;
  localparam int PER = 10;

  logic clk = 0, rst_n = 0;
  logic [2:0] sel = 0;
  logic [11:0] jfield = 0;
  logic cond = 0, ir_shift = 0, ir_pick = 0, lc_load_bus = 0, lc_load_imm = 0, lc_step = 0;
  logic [15:0] ibus = 0;
  logic [7:0] lc_imm = 0;
  logic [11:0] addr;
  logic loop_done;

  int compared = 0, mismatched = 0;
  logic [11:0] qa[$];
  logic qd[$];
  string qt[$];

  logic [11:0] m_addr, m_nxt, m_sav;
  logic [15:0] m_a, m_b;
  logic [7:0] m_cnt;

  always #(PER/2) clk = ~clk;

  useq_next i_useq_next (
    .clk(clk), .rst_n(rst_n), .sel(sel), .jfield(jfield), .cond(cond),
    .ibus(ibus), .ir_shift(ir_shift), .ir_pick(ir_pick),
    .lc_load_bus(lc_load_bus), .lc_load_imm(lc_load_imm), .lc_imm(lc_imm),
    .lc_step(lc_step), .addr(addr), .loop_done(loop_done)
  );

  function automatic logic [7:0] vect(input logic [8:0] op);
    return op[8] ? ~op[7:0] : op[7:0];
  endfunction

  task automatic check(input string tag, input logic [11:0] ea, input logic ed);
    compared++;
    if (addr !== ea || loop_done !== ed) begin
      mismatched++;
      $display("FAIL %s: addr=%0d done=%0b expected addr=%0d done=%0b", tag, addr, loop_done, ea, ed);
    end
  endtask

  task automatic step(input logic [2:0] s, input logic [11:0] jf, input logic c,
                      input logic sh, input logic [15:0] b, input logic pk,
                      input logic lb, input logic li, input logic [7:0] im,
                      input logic st, input string tag);
    logic [8:0] op;
    logic [11:0] t, l;
    @(negedge clk);
    sel = s; jfield = jf; cond = c; ir_shift = sh; ibus = b; ir_pick = pk;
    lc_load_bus = lb; lc_load_imm = li; lc_imm = im; lc_step = st;
    op = pk ? m_b[15:7] : m_a[15:7];
    case (s)
      3'd1, 3'd3: t = jf;
      3'd2: t = c ? jf : m_nxt;
      3'd4: t = m_sav;
      3'd5: t = {3'b000, op};
      default: t = m_nxt;
    endcase
    l = (s == 3'd5) ? {4'h4, vect(op)} : t + 12'd1;
    if (s == 3'd3) m_sav = m_nxt;
    if (sh) begin m_b = m_a; m_a = b; end
    if (lb) m_cnt = b[7:0];
    else if (li) m_cnt = im;
    else if (st && m_cnt != 0) m_cnt = m_cnt - 8'd1;
    m_addr = t; m_nxt = l;
    qa.push_back(m_addr); qd.push_back(m_cnt == 0); qt.push_back(tag);
  endtask

  task automatic simple(input logic [2:0] s, input logic [11:0] jf, input logic c, input string tag);
    step(s, jf, c, 0, 16'h0, 0, 0, 0, 8'h0, 0, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #(PER/4);
      if (qa.size() > 0) check(qt.pop_front(), qa.pop_front(), qd.pop_front());
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    m_addr = 0; m_nxt = 1; m_sav = 0; m_a = 0; m_b = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #(PER/4);
    check("R1", 12'd0, 1'b1);
    @(negedge clk);
    rst_n = 1;
    step(3'd5, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");  // dispatch from cleared A
    simple(3'd0, 0, 0, "R1");                     // -> 0x400
    simple(3'd4, 0, 0, "R1");                     // return reg cleared
    simple(3'd0, 0, 0, "R2");
    simple(3'd6, 0, 0, "R2");
    simple(3'd7, 0, 0, "R2");
    simple(3'd1, 12'd4094, 0, "R3");
    simple(3'd0, 0, 0, "R2");
    simple(3'd0, 0, 0, "R2");                     // wrap to 0
    simple(3'd1, 12'h123, 0, "R3");
    simple(3'd0, 0, 0, "R3");
    simple(3'd2, 12'h300, 0, "R4");
    simple(3'd2, 12'h300, 1, "R4");
    simple(3'd0, 0, 0, "R4");
    simple(3'd3, 12'h7F0, 0, "R5");
    simple(3'd0, 0, 0, "R5");
    simple(3'd1, 12'h050, 0, "R6");
    simple(3'd4, 0, 0, "R6");
    simple(3'd4, 0, 0, "R6");
    step(3'd0, 0, 0, 1, 16'hC2B5, 0, 0, 0, 0, 0, "R7");
    step(3'd0, 0, 0, 1, 16'h1A80, 0, 0, 0, 0, 0, "R7");
    step(3'd5, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");  // A = 1A80
    simple(3'd0, 0, 0, "R8");
    step(3'd5, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R8");  // B = C2B5, bit8 set
    simple(3'd0, 0, 0, "R8");
    simple(3'd0, 0, 0, "R8");
    step(3'd5, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R8");
    simple(3'd3, 12'h111, 0, "R8");               // call saves vector
    simple(3'd4, 0, 0, "R8");
    step(3'd5, 0, 0, 1, 16'hFFFF, 0, 0, 0, 0, 0, "R7"); // dispatch uses old A
    simple(3'd2, 12'h222, 0, "R8");
    step(3'd0, 0, 0, 0, 16'h0103, 0, 1, 0, 0, 0, "R9");
    step(3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
    step(3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
    step(3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
    step(3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
    step(3'd0, 0, 0, 0, 0, 0, 0, 1, 8'd2, 0, "R9");
    step(3'd0, 0, 0, 0, 16'h0000, 0, 1, 1, 8'd9, 1, "R9");
    step(3'd0, 0, 0, 0, 16'h0005, 0, 1, 1, 8'd9, 1, "R9");
    step(3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    @(negedge clk);
    sel = 0; lc_load_bus = 0; lc_load_imm = 0; lc_step = 0; ir_shift = 0;
    repeat (3) @(posedge clk);
    #(PER/2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule